// File: doc/BRIEF.md
# Guarded Sequence Table

This block holds the instruction sequences that a serial-memory command interpreter runs. The table has 32 sequences of four 32-bit words each, so 128 words in all. A host reaches it through a plain register bus made of an address, a write enable, write data and combinational read data. The interpreter reads the table through a separate port that takes a sequence number and a word number.

Changes to the table are guarded by a two-step handshake. The host first writes a fixed key value to a key register. Its very next bus write must then go to the lock-control register and carry a lock or an unlock code. Table writes are accepted only while the table is unlocked. Writes made while it is locked are discarded without any sign. Reads are always served.

Top module: `seqtbl_top`

## Requirements
- R1: After reset the table is unlocked, all 128 words read as zero on both read ports, and the lock-control register reads 0x2.
- R2: Table word k (0..127) sits at byte address 0x200 + 4*k, so sequence n word w sits at 0x200 + 16*n + 4*w. The interpreter port returns word 4*n + w for seqIdx = n, seqWord = w. A bus read of that address returns the same value in the same cycle.
- R3: While the table is unlocked, a bus write to a table address stores the write data in the addressed word.
- R4: While the table is locked, a bus write to a table address leaves every word unchanged.
- R5: Writing 0x5AF05AF0 to the key register (0x18) arms the guard. If the next bus write goes to the lock-control register (0x1C), a value of 0x1 locks the table and a value of 0x2 unlocks it.
- R6: Any bus write that is not the correct key disarms the guard, whatever its address or data. This includes a wrong key, a table write, and a lock-control write. A lock-control write made without the guard armed, or carrying a value other than 0x1 or 0x2, leaves the lock state unchanged.
- R7: Bus reads, meaning cycles with the write enable low, neither arm nor disarm the guard.
- R8: The lock-control register reads 0x1 when locked and 0x2 when unlocked. The key register and every unmapped address read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 12 | Byte address on the register bus |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| seqIdx | input | 5 | Sequence number for the interpreter port |
| seqWord | input | 2 | Word number within the sequence |
| seqData | output | 32 | Table word for the interpreter |

## Verification
The guard's hidden state is the armed flag. If the flag is wrong, the table does not show it right away. It shows at the lock-control register, which reads back the wrong code one cycle after the lock-control write that the flag wrongly let through or wrongly blocked. A wrong lock flag shows at the next table write: the word read back afterwards is either the new value, when the write should have been dropped, or the stale value, when it should have been stored. The sweeps compare every word on both read ports after each phase. A mismatch is therefore seen within one write and one read of the faulty event.

// File: rtl/seqtbl_pkg.sv
package seqtbl_pkg;
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int SEQ_COUNT   = 32;
  localparam int SEQ_WORDS   = 4;
  localparam int TABLE_WORDS = SEQ_COUNT * SEQ_WORDS;
  localparam int SEQ_IDX_W   = $clog2(SEQ_COUNT);
  localparam int SEQ_WORD_W  = $clog2(SEQ_WORDS);
  localparam int TBL_IDX_W   = $clog2(TABLE_WORDS);
  localparam int BYTE_LANES  = DATA_W / 8;
  localparam int LANE_W      = $clog2(BYTE_LANES);

  localparam logic [ADDR_W-1:0] KEY_OFS    = 12'h018;
  localparam logic [ADDR_W-1:0] LOCK_OFS   = 12'h01C;
  localparam logic [ADDR_W-1:0] TABLE_BASE = 12'h200;
  localparam logic [ADDR_W-1:0] TABLE_END  = ADDR_W'(TABLE_BASE + TABLE_WORDS * BYTE_LANES);

  localparam logic [DATA_W-1:0] KEY_VALUE   = 32'h5AF0_5AF0;
  localparam logic [DATA_W-1:0] CODE_LOCK   = 32'h0000_0001;
  localparam logic [DATA_W-1:0] CODE_UNLOCK = 32'h0000_0002;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_TABLE = 2'd1,
    RD_LOCK  = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic                 tableWe;
    logic [TBL_IDX_W-1:0] tableIdx;
    rdSel_e               rdSel;
    logic                 locked;
    logic                 armed;
  } ctlStrobe_t;
endpackage

// File: rtl/seqtbl_ctrl.sv
module seqtbl_ctrl
  import seqtbl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobe_t        strobe
);
  logic              hitKey;
  logic              hitLock;
  logic              hitTable;
  logic [ADDR_W-1:0] tableOfs;
  logic              keyMatch;
  logic              armedQ;
  logic              lockedQ;

  always_comb begin
    hitKey   = (regAddr == KEY_OFS);
    hitLock  = (regAddr == LOCK_OFS);
    hitTable = (regAddr >= TABLE_BASE) && (regAddr < TABLE_END);
    tableOfs = regAddr - TABLE_BASE;
    keyMatch = hitKey && (regWrData == KEY_VALUE);
  end

  // The guard stays armed only across the single bus write that follows the key.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      lockedQ <= 1'b0;
    end else if (regWrEn) begin
      armedQ <= keyMatch;
      if (hitLock && armedQ) begin
        if (regWrData == CODE_LOCK)        lockedQ <= 1'b1;
        else if (regWrData == CODE_UNLOCK) lockedQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.tableWe  = regWrEn && hitTable && !lockedQ;
    strobe.tableIdx = tableOfs[LANE_W +: TBL_IDX_W];
    if (hitTable)     strobe.rdSel = RD_TABLE;
    else if (hitLock) strobe.rdSel = RD_LOCK;
    else              strobe.rdSel = RD_NONE;
    strobe.locked   = lockedQ;
    strobe.armed    = armedQ;
  end
endmodule

// File: rtl/seqtbl_datapath.sv
module seqtbl_datapath
  import seqtbl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [SEQ_IDX_W-1:0]  seqIdx,
  input  logic [SEQ_WORD_W-1:0] seqWord,
  output logic [DATA_W-1:0]     seqData
);
  logic [DATA_W-1:0] tableMem [TABLE_WORDS];

  for (genvar g = 0; g < TABLE_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        tableMem[g] <= '0;
      else if (strobe.tableWe && (strobe.tableIdx == TBL_IDX_W'(g)))
        tableMem[g] <= regWrData;
    end
  end

  always_comb begin
    seqData = tableMem[{seqIdx, seqWord}];
    unique case (strobe.rdSel)
      RD_TABLE: regRdData = tableMem[strobe.tableIdx];
      RD_LOCK:  regRdData = strobe.locked ? CODE_LOCK : CODE_UNLOCK;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/seqtbl_top.sv
module seqtbl_top
  import seqtbl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [SEQ_IDX_W-1:0]  seqIdx,
  input  logic [SEQ_WORD_W-1:0] seqWord,
  output logic [DATA_W-1:0]     seqData
);
  ctlStrobe_t strobe;
  logic       lockedNow;
  logic       armedNow;
  logic       tableWeNow;

  seqtbl_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  seqtbl_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .seqIdx    (seqIdx),
    .seqWord   (seqWord),
    .seqData   (seqData)
  );

  assign lockedNow  = strobe.locked;
  assign armedNow   = strobe.armed;
  assign tableWeNow = strobe.tableWe;
endmodule

// File: rtl/seqtbl_checker.sv
module seqtbl_checker
  import seqtbl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              lockedNow,
  input logic              armedNow,
  input logic              tableWeNow
);
  assert_arm_from_key_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedNow) |-> $past(regWrEn && regAddr == KEY_OFS && regWrData == KEY_VALUE));

  assert_lock_needs_arm_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockedNow) |-> $past(armedNow && regWrEn && regAddr == LOCK_OFS));

  assert_disarm_on_other_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !(regAddr == KEY_OFS && regWrData == KEY_VALUE)) |=> !armedNow);

  assert_read_keeps_arm_R7: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(armedNow));

  assert_locked_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockedNow |-> !tableWeNow);

  assert_lock_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == LOCK_OFS) |-> (regRdData == (lockedNow ? CODE_LOCK : CODE_UNLOCK)));
endmodule

bind seqtbl_top seqtbl_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .lockedNow  (lockedNow),
  .armedNow   (armedNow),
  .tableWeNow (tableWeNow)
);

// File: tb/seqtbl_top_test.sv
module seqtbl_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  seqIdx = '0;
  logic [1:0]  seqWord = '0;
  logic [31:0] seqData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam logic [11:0] A_KEY  = 12'h018;
  localparam logic [11:0] A_LOCK = 12'h01C;
  localparam logic [31:0] KEYV   = 32'h5AF0_5AF0;

  always #2.5 clk = ~clk;

  seqtbl_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .seqIdx(seqIdx), .seqWord(seqWord), .seqData(seqData)
  );

  function automatic logic [31:0] pat(int k, logic [7:0] salt);
    logic [7:0] kb;
    kb = 8'(k);
    return {salt ^ kb, 8'(k * 7), ~kb, 8'hC3};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sweep(string req, logic [7:0] salt, bit zero);
    logic [31:0] d;
    for (int k = 0; k < 128; k++) begin
      logic [31:0] e;
      e = zero ? 32'h0 : pat(k, salt);
      busRead(12'(12'h200 + 4 * k), d);
      check(req, d, e);
      seqIdx = 5'(k / 4); seqWord = 2'(k % 4);
      #1 check(req, seqData, e);
    end
  endtask

  task automatic fill(logic [7:0] salt);
    for (int k = 0; k < 128; k++) busWrite(12'(12'h200 + 4 * k), pat(k, salt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(A_LOCK, d); check("R1 lock after reset", d, 32'h2);
    sweep("R1 table zero", 8'h00, 1'b1);

    // R3 and R2: unlocked fill, both ports
    fill(8'h00);
    sweep("R2/R3 fill readback", 8'h00, 1'b0);

    // R8: other addresses
    busRead(A_KEY, d);   check("R8 key reads zero", d, 32'h0);
    busRead(12'h000, d); check("R8 unmapped low", d, 32'h0);
    busRead(12'h400, d); check("R8 unmapped past table", d, 32'h0);

    // R6: lock without key ignored
    busWrite(A_LOCK, 32'h1);
    busRead(A_LOCK, d); check("R6 lock without key", d, 32'h2);

    // R5: key then lock
    busWrite(A_KEY, KEYV); busWrite(A_LOCK, 32'h1);
    busRead(A_LOCK, d); check("R5 lock with key", d, 32'h1);

    // R4: locked writes dropped
    fill(8'hFF);
    sweep("R4 locked writes dropped", 8'h00, 1'b0);

    // R6: key then table write disarms
    busWrite(A_KEY, KEYV); busWrite(12'h204, 32'hDEAD_BEEF); busWrite(A_LOCK, 32'h2);
    busRead(A_LOCK, d); check("R6 table write disarms", d, 32'h1);
    busRead(12'h204, d); check("R4 locked write dropped", d, pat(1, 8'h00));
    // R6: wrong key
    busWrite(A_KEY, 32'h5AF0_5AF1); busWrite(A_LOCK, 32'h2);
    busRead(A_LOCK, d); check("R6 wrong key", d, 32'h1);
    // R6: bad code disarms
    busWrite(A_KEY, KEYV); busWrite(A_LOCK, 32'h3);
    busRead(A_LOCK, d); check("R6 bad code no change", d, 32'h1);
    busWrite(A_LOCK, 32'h2);
    busRead(A_LOCK, d); check("R6 bad code disarmed", d, 32'h1);

    // R7: reads between key and unlock keep the guard armed
    busWrite(A_KEY, KEYV);
    busRead(12'h200, d); busRead(A_KEY, d); busRead(A_LOCK, d);
    busWrite(A_LOCK, 32'h2);
    busRead(A_LOCK, d); check("R7 reads keep arm", d, 32'h2);

    // R5: repeated key stays armed
    busWrite(A_KEY, KEYV); busWrite(A_KEY, KEYV); busWrite(A_LOCK, 32'h1);
    busRead(A_LOCK, d); check("R5 double key lock", d, 32'h1);
    busWrite(A_KEY, KEYV); busWrite(A_LOCK, 32'h2);
    busRead(A_LOCK, d); check("R5 unlock", d, 32'h2);

    // R3: writes accepted again after unlock
    fill(8'h3C);
    sweep("R3 writes after unlock", 8'h3C, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule